// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block turns two active-low external interrupt pins into interrupt request flags. Each pin passes through its own two-flop synchronizer and is then sampled on every system clock. A per-pin mode bit picks how the request flag is made. In edge mode a high-to-low transition of the synchronized pin sets a sticky flag, which clears when the interrupt controller acknowledges the vector. In level mode the flag simply tracks the inverted, synchronized pin.

Software sees the mode bits and the flags as one control byte, which it can both read and write. A write sets the mode bits and, in edge mode, sets or clears the flags directly. Each channel runs a two-state detector. `DET_ARMED` means the last synchronized sample was high, and `DET_LOW` means it was low. The transition `fall` goes from `DET_ARMED` to `DET_LOW` when a low sample arrives, and it is the edge event. The transition `release` goes from `DET_LOW` back to `DET_ARMED` when a high sample arrives. In every other case each state holds.

Top module: `extint_detect`

## Requirements
- R1: After reset every mode bit and every flag is 0 (level mode), so `ctl_rdata` reads 8'h00 and `irq_req` reads 2'b00 while both pins are high.
- R2: Control byte layout: bit 0 is the mode of pin 0 (1 = edge, 0 = level), bit 1 is the flag of pin 0, bit 2 is the mode of pin 1 and bit 3 is the flag of pin 1. Bits 7:4 always read 0, and writing 1s to them changes nothing. `irq_req[i]` equals the flag of pin i.
- R3: In edge mode a pin that goes from high to low sets its flag on the third rising clock edge after the change. The first of those edges is the one that first samples the low level.
- R4: In edge mode a pin that stays low, or that returns high, does not set the flag again. Only a new high-to-low transition does.
- R5: In edge mode, `vec_ack[i]` high at a clock edge clears flag i at that edge.
- R6: In level mode the flag equals the inverted pin, delayed by three clock edges, in both directions. `vec_ack` has no effect in this mode.
- R7: A write (`ctl_we` high) loads both mode bits. In edge mode it also loads the written flag values, which can set or clear a flag. In level mode the written flag value is ignored.
- R8: When an edge is detected in the same cycle as a software clear or an acknowledge of that flag, the flag ends up set.
- R9: The two channels are independent, and edges on both pins in the same cycle set both flags.
- R10: A low pulse that lasts exactly one clock cycle is detected in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n | input | 2 | Active-low interrupt pins, asynchronous |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| vec_ack | input | 2 | Vector acknowledge, one bit per pin |
| ctl_rdata | output | 8 | Control byte read value |
| irq_req | output | 2 | Interrupt request flags |

## Verification
The bench checks the exact latency through the synchronizer and the detector in edge mode and in level mode. A design with one stage too few or too many would raise or drop the flag one cycle early or late. It holds a pin low across an acknowledge, which catches a detector that treats a low level as a new edge and re-arms the flag. It puts an edge in the same cycle as a software clear and in the same cycle as an acknowledge, where the wrong priority would lose the interrupt. It also drives a single-cycle pulse, drives both pins at once, and writes a flag bit in level mode, where a design that latched the written value would report a phantom request.

// File: rtl/extint_pkg.sv
package extint_pkg;

    // Detector state: what the last synchronized sample was
    typedef enum logic {
        DET_ARMED = 1'b0,   // last sample high, a low sample is an edge
        DET_LOW   = 1'b1    // last sample low, wait for release
    } det_state_e;

    // Control byte layout: per channel a pair {flag, mode}
    localparam int CH_STRIDE = 2;
    localparam int MODE_OFS  = 0;
    localparam int FLAG_OFS  = 1;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/extint_channel.sv
module extint_channel
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,   // synchronized pin, active low
    input  logic wr_en,
    input  logic wr_mode,
    input  logic wr_flag,
    input  logic ack,
    output logic mode_q,     // 1 = edge, 0 = level
    output logic flag_q
);

    det_state_e state_q, state_d;
    logic       fall_evt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DET_ARMED;
        else        state_q <= state_d;
    end

    // Next state and edge event
    always_comb begin
        state_d  = state_q;
        fall_evt = 1'b0;
        unique case (state_q)
            DET_ARMED: begin
                if (!pin_sync) begin       // fall
                    state_d  = DET_LOW;
                    fall_evt = 1'b1;
                end
            end
            DET_LOW: begin
                if (pin_sync) begin        // release
                    state_d = DET_ARMED;
                end
            end
            default: state_d = DET_ARMED;
        endcase
    end

    // Mode bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mode_q <= 1'b0;
        else if (wr_en) mode_q <= wr_mode;
    end

    // Output: request flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (!mode_q) begin
            flag_q <= ~pin_sync;
        end else if (fall_evt) begin
            flag_q <= 1'b1;
        end else if (wr_en) begin
            flag_q <= wr_flag;
        end else if (ack) begin
            flag_q <= 1'b0;
        end
    end

    // R3 / R8: an edge seen in edge mode always leaves the flag set
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && state_q == DET_ARMED && !pin_sync) |=> flag_q);

    // R6: level mode follows the inverted synchronized pin
    a_r6_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q) |=> (flag_q == !$past(pin_sync)));

    // R5: an acknowledge with no competing cause clears the flag
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && ack && !wr_en && !(state_q == DET_ARMED && !pin_sync))
        |=> !flag_q);

    // R4: the flag only rises for an edge, a software set or level mode
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(!mode_q || (wr_en && wr_flag)
                                || (state_q == DET_ARMED && !pin_sync)));

endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] ext_pin_n,
    input  logic                ctl_we,
    input  logic [REG_W-1:0]    ctl_wdata,
    input  logic [NUM_PINS-1:0] vec_ack,
    output logic [REG_W-1:0]    ctl_rdata,
    output logic [NUM_PINS-1:0] irq_req
);

    localparam int USED_W = CH_STRIDE * NUM_PINS;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] mode_bits;
    logic [NUM_PINS-1:0] flag_bits;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_ch
            extint_sync #(
                .STAGES    (SYNC_STAGES),
                .RESET_VAL (1'b1)
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (ext_pin_n[i]),
                .q     (pin_sync[i])
            );

            extint_channel u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_sync (pin_sync[i]),
                .wr_en    (ctl_we),
                .wr_mode  (ctl_wdata[CH_STRIDE*i + MODE_OFS]),
                .wr_flag  (ctl_wdata[CH_STRIDE*i + FLAG_OFS]),
                .ack      (vec_ack[i]),
                .mode_q   (mode_bits[i]),
                .flag_q   (flag_bits[i])
            );
        end

        if (REG_W > USED_W) begin : g_spare
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^ctl_wdata[REG_W-1:USED_W];
        end
    endgenerate

    always_comb begin
        ctl_rdata = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            ctl_rdata[CH_STRIDE*i + MODE_OFS] = mode_bits[i];
            ctl_rdata[CH_STRIDE*i + FLAG_OFS] = flag_bits[i];
        end
    end

    assign irq_req = flag_bits;

endmodule

// File: tb/sim_extint_detect.sv
module sim_extint_detect;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_pin_n = 2'b11;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [1:0] vec_ack = 2'b00;
    logic [7:0] ctl_rdata;
    logic [1:0] irq_req;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        string      tag;
        logic [7:0] rd;
    } exp_t;

    exp_t sb_q[$];

    extint_detect u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin_n (ext_pin_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .vec_ack   (vec_ack),
        .ctl_rdata (ctl_rdata),
        .irq_req   (irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares due items away from the active edge
    always @(negedge clk) begin
        exp_t e;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            e = sb_q.pop_front();
            checks++;
            if (e.due != cyc || ctl_rdata !== e.rd || irq_req !== {e.rd[3], e.rd[1]}) begin
                errors++;
                $display("FAIL %s cyc=%0d rdata=%02h irq=%b expected rdata=%02h irq=%b",
                         e.tag, cyc, ctl_rdata, irq_req, e.rd, {e.rd[3], e.rd[1]});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input int dly, input string tag, input logic [7:0] rd);
        exp_t e;
        e.due = cyc + dly;
        e.tag = tag;
        e.rd  = rd;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [7:0] d, input string tag, input logic [7:0] rd);
        ctl_we    = 1'b1;
        ctl_wdata = d;
        push_exp(1, tag, rd);
        tick(1);
        ctl_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        push_exp(1, "R1 reset", 8'h00);
        tick(2);

        // R6 level mode on pin 0, ack ignored
        ext_pin_n[0] = 1'b0;
        push_exp(2, "R6 level not yet", 8'h00);
        push_exp(3, "R6 level low", 8'h02);
        tick(3);
        vec_ack[0] = 1'b1;
        push_exp(1, "R6 ack ignored", 8'h02);
        tick(1);
        vec_ack[0] = 1'b0;
        ext_pin_n[0] = 1'b1;
        push_exp(2, "R6 level hold", 8'h02);
        push_exp(3, "R6 level release", 8'h00);
        tick(4);

        // R7 flag write ignored in level mode
        wr(8'h02, "R7 level write ignored", 8'h00);

        // R2 switch to edge mode, upper bits inert
        wr(8'h05, "R2 mode bits", 8'h05);
        wr(8'hF5, "R2 upper bits", 8'h05);

        // R3 edge sets, R5 ack clears, R4 held low no re-set
        ext_pin_n[0] = 1'b0;
        push_exp(2, "R3 edge not yet", 8'h05);
        push_exp(3, "R3 edge set", 8'h07);
        tick(3);
        vec_ack[0] = 1'b1;
        push_exp(1, "R5 ack clears", 8'h05);
        tick(1);
        vec_ack[0] = 1'b0;
        push_exp(4, "R4 held low", 8'h05);
        tick(4);
        ext_pin_n[0] = 1'b1;
        push_exp(4, "R4 release", 8'h05);
        tick(4);

        // R10 single-cycle pulse on pin 1, R9 pin 0 untouched
        ext_pin_n[1] = 1'b0;
        tick(1);
        ext_pin_n[1] = 1'b1;
        push_exp(2, "R10 pulse R9", 8'h0D);
        tick(4);

        // R7 software set and clear in edge mode
        wr(8'h05, "R7 sw clear", 8'h05);
        wr(8'h07, "R7 sw set", 8'h07);
        wr(8'h05, "R7 sw clear2", 8'h05);

        // R8 edge beats software clear
        wr(8'h07, "R7 sw set2", 8'h07);
        ext_pin_n[0] = 1'b0;
        tick(2);
        ctl_we    = 1'b1;
        ctl_wdata = 8'h05;
        push_exp(1, "R8 edge vs sw clear", 8'h07);
        tick(1);
        ctl_we = 1'b0;
        push_exp(2, "R8 after", 8'h07);
        tick(2);
        ext_pin_n[0] = 1'b1;
        tick(4);

        // R8 edge beats acknowledge
        ext_pin_n[0] = 1'b0;
        tick(2);
        vec_ack[0] = 1'b1;
        push_exp(1, "R8 edge vs ack", 8'h07);
        tick(1);
        vec_ack[0] = 1'b1;
        push_exp(1, "R5 ack alone", 8'h05);
        tick(1);
        vec_ack[0] = 1'b0;
        ext_pin_n[0] = 1'b1;
        tick(4);

        // R9 both pins together
        ext_pin_n = 2'b00;
        push_exp(3, "R9 both set", 8'h0F);
        tick(4);
        vec_ack = 2'b11;
        push_exp(1, "R5 both ack", 8'h05);
        tick(1);
        vec_ack = 2'b00;
        ext_pin_n = 2'b11;
        push_exp(4, "R4 rising no set", 8'h05);
        tick(4);

        // R6 level mode on pin 1
        wr(8'h00, "R7 back to level", 8'h00);
        ext_pin_n[1] = 1'b0;
        push_exp(3, "R6 pin1 level", 8'h08);
        tick(4);
        ext_pin_n[1] = 1'b1;
        push_exp(3, "R6 pin1 release", 8'h00);
        tick(5);

        if (sb_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: pending=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule